// File: doc/BRIEF.md
# Configuration Stream Unpacker

This engine walks a compact configuration image held in a word-addressed source memory and turns it into ordinary register writes. Starting at a given pointer, it fetches 32-bit words one at a time. Each word is either a self-contained register write or the header of a run of values that are packed one, two or four to a data word. A run writes to consecutive register addresses, using a stride of one or two. Packing many narrow registers densely keeps the image small, and the engine expands it back without software help.

An optional verify mode reads every target register before writing it. The engine compares the old contents with the new value over the active width only, and counts the registers that differed. A header with a value count of zero ends the image. When it sees one, the engine returns to idle and pulses `done`. It leaves the pointer just past the terminator and the mismatch total on its outputs. Source fetches and register accesses each use a valid/ready handshake, and the engine never has more than one access outstanding.

Top module: `cfg_unpack_engine`

## Requirements
- R1: A source word with bit 31 set is one register write: bits 30..17 give a 14-bit register address (zero-extended to 16 bits) and bits 16..0 give the value, zero-extended to 32 bits.
- R2: A source word with bit 31 clear is a run header: bits 30..15 start address, bits 14..7 value count, bits 6..2 width minus one, bit 1 sign-extend flag, bit 0 stride select.
- R3: A width-minus-one of 0 to 7 packs four 8-bit values per data word, taken from bits 7..0 first, then 15..8, 23..16 and 31..24.
- R4: A width-minus-one of 8 to 15 packs two 16-bit values per data word, bits 15..0 before bits 31..16.
- R5: A width-minus-one of 16 or more carries one full 32-bit value per data word.
- R6: After each write of a run the target address grows by 1 when the stride bit is 0 and by 2 when it is 1.
- R7: When a run's count is used up partway through a data word, the rest of that word is discarded and the next source word is decoded as a new header or single write.
- R8: With the sign-extend flag set, 8-bit and 16-bit values are sign-extended to 32 bits, otherwise zero-extended; 32-bit values pass unchanged whatever the flag.
- R9: In verify mode each target is read before it is written, and the mismatch count grows by one exactly when the read data and the new value differ within the active width (8, 16 or 32 bits for runs, 17 bits for single writes).
- R10: A header with count zero stops the engine: `done` pulses for one cycle, `busy` falls, `end_ptr` points one past the terminator, and no further access is issued.
- R11: A source fetch or register access, once raised, keeps its address, data and direction stable until it is accepted. Source and register accesses never overlap.
- R12: With verify mode off, no register read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin unpacking (sampled in idle) |
| start_ptr | input | PTR_W | Source address of the first image word |
| verify_en | input | 1 | Read-compare before each write, latched at start |
| busy | output | 1 | Engine is working through an image |
| done | output | 1 | One-cycle pulse when the terminator is consumed |
| end_ptr | output | PTR_W | Source pointer after the terminator |
| err_count | output | ERR_W | Verify mismatches in the last image (saturating) |
| src_rd_valid | output | 1 | Source fetch request |
| src_rd_addr | output | PTR_W | Source fetch address |
| src_rd_ready | input | 1 | Source fetch accepted, data valid this cycle |
| src_rd_data | input | 32 | Source word |
| reg_valid | output | 1 | Register access request |
| reg_write | output | 1 | 1 = write, 0 = verify read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 32 | Register write value |
| reg_ready | input | 1 | Register access accepted, read data valid this cycle |
| reg_rdata | input | 32 | Register read data |

## Verification
The bench aims at runs whose count ends inside a data word. It fills the unused lanes with non-zero filler, so an engine that keeps unpacking would emit extra writes, and one that skips the next word would misread the following single write. Sign extension is tried on 8-bit values with the top bit set and clear, on 16-bit values, and on a 32-bit run with the flag set; a wrong width class shows up as corrupt high bits. In verify mode, targets whose stale high bits differ only outside the active width must not be counted, while a one-bit difference inside the width must be. Random ready stalls on both ports expose any request that drops or changes before it is accepted.

// File: rtl/cfg_unpack_pkg.sv
package cfg_unpack_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_AW  = 16;
    localparam int CNT_W   = 8;
    localparam int SDATA_W = 17;

    typedef enum logic [1:0] {
        PK_8  = 2'd0,
        PK_16 = 2'd1,
        PK_32 = 2'd2,
        PK_17 = 2'd3
    } pack_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_DAT  = 3'd2,
        ST_VRD  = 3'd3,
        ST_WR   = 3'd4
    } state_e;

    typedef struct packed {
        logic                single;
        logic [REG_AW-1:0]   addr;
        logic [CNT_W-1:0]    count;
        pack_e               pack;
        logic                sext;
        logic                step2;
        logic [SDATA_W-1:0]  sdata;
    } hdr_t;

    function automatic pack_e pack_of(input logic [4:0] wm1);
        if (wm1 >= 5'd16)     return PK_32;
        else if (wm1 >= 5'd8) return PK_16;
        else                  return PK_8;
    endfunction

    function automatic logic [1:0] last_lane(input pack_e p);
        case (p)
            PK_8:    return 2'd3;
            PK_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input pack_e p);
        case (p)
            PK_8:    return 32'h0000_00FF;
            PK_16:   return 32'h0000_FFFF;
            PK_17:   return 32'h0001_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
    import cfg_unpack_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    always_comb begin
        hdr.single = word[31];
        hdr.sdata  = word[16:0];
        if (word[31]) begin
            hdr.addr  = {2'b00, word[30:17]};
            hdr.count = 8'd1;
            hdr.pack  = PK_17;
            hdr.sext  = 1'b0;
            hdr.step2 = 1'b0;
        end else begin
            hdr.addr  = word[30:15];
            hdr.count = word[14:7];
            hdr.pack  = pack_of(word[6:2]);
            hdr.sext  = word[1];
            hdr.step2 = word[0];
        end
    end
endmodule

// File: rtl/cfg_lane_extract.sv
module cfg_lane_extract
    import cfg_unpack_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  pack_e             pack,
    input  logic              sext,
    input  logic [1:0]        lane,
    output logic [WORD_W-1:0] value
);
    localparam int NBYTES = WORD_W / 8;

    logic [7:0]  bytes [NBYTES];
    logic [7:0]  b;
    logic [15:0] h;

    for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
        assign bytes[g] = word[8*g +: 8];
    end

    always_comb begin
        b = bytes[lane];
        h = lane[0] ? word[31:16] : word[15:0];
        case (pack)
            PK_8:    value = sext ? {{24{b[7]}}, b}  : {24'b0, b};
            PK_16:   value = sext ? {{16{h[15]}}, h} : {16'b0, h};
            default: value = word;
        endcase
    end
endmodule

// File: rtl/cfg_mismatch_count.sv
module cfg_mismatch_count #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic [31:0]      rd_val,
    input  logic [31:0]      new_val,
    input  logic [31:0]      mask,
    output logic [ERR_W-1:0] count
);
    logic differ;
    assign differ = |((rd_val ^ new_val) & mask);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (sample && differ && (count != {ERR_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_unpack_engine.sv
module cfg_unpack_engine
    import cfg_unpack_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic              verify_en,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  end_ptr,
    output logic [ERR_W-1:0]  err_count,
    output logic              src_rd_valid,
    output logic [PTR_W-1:0]  src_rd_addr,
    input  logic              src_rd_ready,
    input  logic [31:0]       src_rd_data,
    output logic              reg_valid,
    output logic              reg_write,
    output logic [15:0]       reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ready,
    input  logic [31:0]       reg_rdata
);
    state_e             state;
    logic [PTR_W-1:0]   ptr;
    logic [REG_AW-1:0]  addr_q;
    logic [CNT_W-1:0]   remain_q;
    pack_e              pack_q;
    logic               sext_q;
    logic               step2_q;
    logic [1:0]         lane_q;
    logic [WORD_W-1:0]  data_q;
    logic [WORD_W-1:0]  val_q;
    logic               verify_q;
    logic               done_q;

    hdr_t               hdr;
    logic [WORD_W-1:0]  ext_word;
    logic [1:0]         ext_lane;
    logic [WORD_W-1:0]  ext_val;
    logic               src_take;
    logic               reg_take;

    cfg_hdr_decode i_dec (
        .word (src_rd_data),
        .hdr  (hdr)
    );

    assign ext_word = (state == ST_DAT) ? src_rd_data : data_q;
    assign ext_lane = (state == ST_DAT) ? 2'd0 : (lane_q + 2'd1);

    cfg_lane_extract i_ext (
        .word  (ext_word),
        .pack  (pack_q),
        .sext  (sext_q),
        .lane  (ext_lane),
        .value (ext_val)
    );

    cfg_mismatch_count #(.ERR_W(ERR_W)) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == ST_IDLE && start),
        .sample  (state == ST_VRD && reg_ready),
        .rd_val  (reg_rdata),
        .new_val (val_q),
        .mask    (width_mask(pack_q)),
        .count   (err_count)
    );

    assign src_rd_valid = (state == ST_HDR) || (state == ST_DAT);
    assign src_rd_addr  = ptr;
    assign reg_valid    = (state == ST_VRD) || (state == ST_WR);
    assign reg_write    = (state == ST_WR);
    assign reg_addr     = addr_q;
    assign reg_wdata    = val_q;
    assign busy         = (state != ST_IDLE);
    assign done         = done_q;
    assign end_ptr      = ptr;
    assign src_take     = src_rd_valid && src_rd_ready;
    assign reg_take     = reg_valid && reg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            pack_q   <= PK_8;
            sext_q   <= 1'b0;
            step2_q  <= 1'b0;
            lane_q   <= '0;
            data_q   <= '0;
            val_q    <= '0;
            verify_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr      <= start_ptr;
                        verify_q <= verify_en;
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (src_take) begin
                        ptr      <= ptr + 1'b1;
                        addr_q   <= hdr.addr;
                        remain_q <= hdr.count;
                        pack_q   <= hdr.pack;
                        sext_q   <= hdr.sext;
                        step2_q  <= hdr.step2;
                        if (hdr.single) begin
                            val_q <= {{(WORD_W-SDATA_W){1'b0}}, hdr.sdata};
                            state <= verify_q ? ST_VRD : ST_WR;
                        end else if (hdr.count == '0) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_DAT;
                        end
                    end
                end
                ST_DAT: begin
                    if (src_take) begin
                        ptr    <= ptr + 1'b1;
                        data_q <= src_rd_data;
                        lane_q <= 2'd0;
                        val_q  <= ext_val;
                        state  <= verify_q ? ST_VRD : ST_WR;
                    end
                end
                ST_VRD: begin
                    if (reg_take) state <= ST_WR;
                end
                ST_WR: begin
                    if (reg_take) begin
                        remain_q <= remain_q - 1'b1;
                        addr_q   <= addr_q + (step2_q ? 16'd2 : 16'd1);
                        if (remain_q == 8'd1) begin
                            state <= ST_HDR;
                        end else if (lane_q == last_lane(pack_q)) begin
                            state <= ST_DAT;
                        end else begin
                            lane_q <= lane_q + 2'd1;
                            val_q  <= ext_val;
                            state  <= verify_q ? ST_VRD : ST_WR;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_unpack_checker.sv
module cfg_unpack_checker #(
    parameter int PTR_W = 8,
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             src_rd_valid,
    input logic             src_rd_ready,
    input logic [PTR_W-1:0] src_rd_addr,
    input logic             reg_valid,
    input logic             reg_ready,
    input logic             reg_write,
    input logic [15:0]      reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [ERR_W-1:0] err_count,
    input logic             verify_q
);
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        src_rd_valid && !src_rd_ready |=> src_rd_valid && $stable(src_rd_addr)); // R11

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_write)); // R11

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(src_rd_valid && reg_valid)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !src_rd_valid && !reg_valid); // R10

    AST_NO_PLAIN_READ: assert property (@(posedge clk) disable iff (rst)
        reg_valid && !reg_write |-> verify_q); // R12

    AST_ERR_MONO: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> err_count >= $past(err_count)); // R9

    AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && (err_count != $past(err_count)) |-> $past(reg_valid && !reg_write && reg_ready)); // R9
endmodule

bind cfg_unpack_engine cfg_unpack_checker #(.PTR_W(PTR_W), .ERR_W(ERR_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .src_rd_valid (src_rd_valid),
    .src_rd_ready (src_rd_ready),
    .src_rd_addr  (src_rd_addr),
    .reg_valid    (reg_valid),
    .reg_ready    (reg_ready),
    .reg_write    (reg_write),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .err_count    (err_count),
    .verify_q     (verify_q)
);

// File: tb/test_cfg_unpack_engine.sv
module test_cfg_unpack_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 8;
    localparam int ERR_W      = 16;
    localparam int RDEPTH     = 16384;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [PTR_W-1:0]  start_ptr = '0;
    logic              verify_en = 1'b0;
    logic              busy, done;
    logic [PTR_W-1:0]  end_ptr;
    logic [ERR_W-1:0]  err_count;
    logic              src_rd_valid;
    logic [PTR_W-1:0]  src_rd_addr;
    logic              src_rd_ready = 1'b0;
    logic [31:0]       src_rd_data;
    logic              reg_valid, reg_write;
    logic [15:0]       reg_addr;
    logic [31:0]       reg_wdata;
    logic              reg_ready = 1'b0;
    logic [31:0]       reg_rdata;

    logic [31:0] mem    [0:255];
    logic [31:0] regs   [0:RDEPTH-1];
    logic [31:0] shadow [0:RDEPTH-1];

    logic [47:0] exp_q [$];
    string       tag_q [$];
    int n_checks = 0, n_errors = 0;
    int wp = 0, exp_errs = 0, reads_seen = 0, writes_seen = 0;
    bit verify_mode = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_rd_data = mem[src_rd_addr];
    assign reg_rdata   = regs[reg_addr[13:0]];

    cfg_unpack_engine #(.PTR_W(PTR_W), .ERR_W(ERR_W)) i_cfg_unpack_engine (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr), .verify_en(verify_en),
        .busy(busy), .done(done), .end_ptr(end_ptr), .err_count(err_count),
        .src_rd_valid(src_rd_valid), .src_rd_addr(src_rd_addr), .src_rd_ready(src_rd_ready),
        .src_rd_data(src_rd_data), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [31:0] d,
                             input logic [31:0] mask, input string tag);
        exp_q.push_back({a, d});
        tag_q.push_back(tag);
        if (verify_mode && (((shadow[a[13:0]] ^ d) & mask) != 0)) exp_errs++;
        shadow[a[13:0]] = d;
    endtask

    task automatic put_single(input logic [13:0] a, input logic [16:0] d, input string tag);
        push_word({1'b1, a, d});
        expect_wr({2'b00, a}, {15'b0, d}, 32'h0001_FFFF, tag);
    endtask

    task automatic put_block(input logic [15:0] a, input int wm1, input bit se, input bit st,
                             input logic [31:0] vals [$], input string tag);
        int per;
        int n;
        logic [31:0] w;
        logic [31:0] e;
        logic [31:0] mask;
        n   = vals.size();
        per = (wm1 >= 16) ? 1 : ((wm1 >= 8) ? 2 : 4);
        push_word({1'b0, a, n[7:0], wm1[4:0], se, st});
        w = 32'hA5A5_A5A5;
        for (int i = 0; i < n; i++) begin
            int l;
            logic [31:0] v;
            l = i % per;
            v = vals[i];
            if (l == 0) w = 32'hA5A5_A5A5;
            if (per == 4) begin
                w[8*l +: 8] = v[7:0];
                e    = se ? {{24{v[7]}}, v[7:0]} : {24'b0, v[7:0]};
                mask = 32'h0000_00FF;
            end else if (per == 2) begin
                w[16*l +: 16] = v[15:0];
                e    = se ? {{16{v[15]}}, v[15:0]} : {16'b0, v[15:0]};
                mask = 32'h0000_FFFF;
            end else begin
                w    = v;
                e    = v;
                mask = 32'hFFFF_FFFF;
            end
            expect_wr(a + 16'(i * (st ? 2 : 1)), e, mask, tag);
            if (l == per - 1 || i == n - 1) push_word(w);
        end
    endtask

    task automatic run_stream(input logic [PTR_W-1:0] sp, input bit ver, input string tag);
        int expect_reads;
        expect_reads = exp_q.size();
        reads_seen = 0;
        @(negedge clk);
        start_ptr = sp;
        verify_en = ver;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        while (!done && !finished) @(negedge clk);
        if (finished) return;
        check(end_ptr == PTR_W'(wp), "R10", "end pointer", 64'(end_ptr), 64'(wp));
        check(err_count == ERR_W'(exp_errs), "R9", {"mismatch count ", tag}, 64'(err_count), 64'(exp_errs));
        check(exp_q.size() == 0, "R7", "writes still expected", 64'(exp_q.size()), 64'd0);
        if (ver) check(reads_seen == expect_reads, "R9", "verify reads", 64'(reads_seen), 64'(expect_reads));
        else     check(reads_seen == 0, "R12", "reads with verify off", 64'(reads_seen), 64'd0);
        @(negedge clk);
        check(!done && !busy, "R10", "done pulse and busy after stop", {62'b0, done, busy}, 64'd0);
    endtask

    // responder and scoreboard monitor
    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            if (rst) begin
                src_rd_ready = 1'b0;
                reg_ready    = 1'b0;
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                src_rd_ready = (lfsr[1:0] != 2'b00);
                reg_ready    = (lfsr[4:3] != 2'b00);
                if (reg_valid && reg_ready) begin
                    if (reg_write) begin
                        writes_seen++;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R7", "unexpected write", {reg_addr, reg_wdata}, 64'd0);
                        end else begin
                            logic [47:0] it;
                            string tg;
                            it = exp_q.pop_front();
                            tg = tag_q.pop_front();
                            check({reg_addr, reg_wdata} == it, tg, "write addr/data",
                                  64'({reg_addr, reg_wdata}), 64'(it));
                        end
                        regs[reg_addr[13:0]] = reg_wdata;
                    end else begin
                        reads_seen++;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v [$];
        for (int i = 0; i < RDEPTH; i++) begin
            regs[i]   = 32'h0;
            shadow[i] = 32'h0;
        end
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !src_rd_valid && !reg_valid && err_count == 0, "R10", "reset state",
              {59'b0, busy, done, src_rd_valid, reg_valid, |err_count}, 64'd0);

        // image A, verify off
        verify_mode = 0;
        exp_errs    = 0;
        wp          = 0;
        put_single(14'h0123, 17'h1ABCD, "R1");
        v = '{32'h11, 32'h82, 32'h33, 32'h44, 32'hF5, 32'h66};
        put_block(16'h0200, 7, 0, 0, v, "R2 R3 R7");
        put_single(14'h3FFF, 17'h00001, "R1 R7");
        v = '{32'h8001, 32'h1234, 32'hFFFF};
        put_block(16'h0300, 15, 1, 1, v, "R4 R6 R8");
        v = '{32'h8000_0000, 32'h1234_5678};
        put_block(16'h0400, 16, 1, 0, v, "R5 R8");
        v = '{32'h80, 32'h7F, 32'hFE, 32'h01, 32'hC3};
        put_block(16'h0500, 4, 1, 1, v, "R3 R6 R8");
        v = '{32'h9ABC, 32'h0001};
        put_block(16'h1000, 9, 0, 0, v, "R4 R8");
        push_word(32'h0);
        run_stream(8'd0, 1'b0, "image A");

        // image B, verify on
        verify_mode = 1;
        exp_errs    = 0;
        wp          = 128;
        regs[14'h600] = 32'hFFFF_FF11; shadow[14'h600] = 32'hFFFF_FF11;
        regs[14'h601] = 32'h0000_0022; shadow[14'h601] = 32'h0000_0022;
        regs[14'h602] = 32'h0000_0000; shadow[14'h602] = 32'h0000_0000;
        regs[14'h603] = 32'h0000_0144; shadow[14'h603] = 32'h0000_0144;
        regs[14'h700] = 32'hFFFF_FFFF; shadow[14'h700] = 32'hFFFF_FFFF;
        regs[14'h701] = 32'h0002_0005; shadow[14'h701] = 32'h0002_0005;
        regs[14'h800] = 32'h0000_0001; shadow[14'h800] = 32'h0000_0001;
        regs[14'h801] = 32'h0000_0003; shadow[14'h801] = 32'h0000_0003;
        v = '{32'h11, 32'h22, 32'h33, 32'h44};
        put_block(16'h0600, 7, 0, 0, v, "R9 R3");
        put_single(14'h0700, 17'h1FFFF, "R9 R1");
        put_single(14'h0701, 17'h00005, "R9 R1");
        v = '{32'h1, 32'h2};
        put_block(16'h0800, 31, 0, 0, v, "R9 R5");
        push_word(32'h0);
        check(exp_errs == 2, "R9", "bench model mismatch total", 64'(exp_errs), 64'd2);
        run_stream(8'd128, 1'b1, "image B");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule